// File: doc/BRIEF.md
# Static Memory Bank Sequencer

This block connects an internal 32-bit request port to an external bus for static memories such as ROM, SRAM and flash. The top three bits of a 28-bit request address pick one of eight banks. Each bank covers 32 MB, and its base address is fixed by the decode rather than by configuration. When the top address bit is clear, one of four static banks is selected. When it is set, one of four dynamic banks is selected. This block only reports a dynamic-bank request; it does not run any bus cycle for it.

Each static bank has its own 2-bit width code and its own 4-bit access-cycle count. A 32-bit request to a bank narrower than 32 bits is split into two or four beats that go out back to back at ascending addresses. Every beat holds its strobe for the programmed count plus one clock. The beat is then stretched one clock at a time for as long as the external wait input is high in the beat's final cycle. One select input chooses how the bytes of the word map onto successive narrow beats (little-endian or big-endian). Read beats are assembled into one word, which is returned together with a one-cycle completion pulse.

Top module: `stbank_ctrl`

## Requirements
- R1: Address bits [27:25] select the bank. Values 0 to 3 select a static bank, which drives its own active-low select line `mem_cs_n[n]` (n = bits [26:25]) for the whole access. The bank's width and cycle fields are `cfg_width[2n+1:2n]` and `cfg_acc[4n+3:4n]`.
- R2: A request with bit 27 set is not driven on the external bus. In the cycle after acceptance, `dyn_flag` is high for exactly one cycle and `dyn_bank` holds bits [26:25]. No select line goes low and no completion pulse follows.
- R3: The width code gives the number of beats: 0 means 8 bits and four beats, 1 means 16 bits and two beats, 2 or 3 means 32 bits and one beat. Beat k drives `mem_addr` = (bits [24:2] of the request address, followed by 00) + k × (bytes per beat). Request address bits [1:0] are ignored.
- R4: With no wait, every beat keeps its strobe low for exactly (access count + 1) clock cycles. The next beat starts in the following cycle.
- R5: `mem_wait` is looked at only in the last cycle of a beat. Each cycle in which it is high there adds one more cycle to the beat. A high level in earlier cycles of the beat has no effect.
- R6: A read holds `mem_oe_n` low and `mem_we_n` high. A write does the reverse. At most one select line is low at any time, and the two strobes are never low together.
- R7: Little-endian (`cfg_big` = 0): on the low lanes of `mem_dout`/`mem_din`, beat k carries word byte k (8-bit bank) or word halfword k (16-bit bank). The unused upper lanes of `mem_dout` are zero.
- R8: Big-endian (`cfg_big` = 1): beat k carries word byte 3−k (8-bit bank) or word halfword 1−k (16-bit bank). A 32-bit bank passes the word through unchanged.
- R9: `resp_done` is high for one cycle, in the cycle that follows the final beat. On a read, `resp_rdata` then holds the assembled word.
- R10: While reset is held, and after it is released, all select lines and both strobes are high and `resp_done` and `dyn_flag` are low.
- R11: `req_valid` is ignored while an access is running, including that access's final cycle. A request presented during that time never starts a bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 8 | Width code per static bank, 2 bits each |
| cfg_acc | input | 16 | Access-cycle count per static bank, 4 bits each |
| cfg_big | input | 1 | 1 = big-endian beat order |
| req_valid | input | 1 | Request present; taken when no access is running |
| req_addr | input | 28 | Request byte address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write word |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Assembled read word |
| dyn_flag | output | 1 | Pulse for a request to a dynamic bank |
| dyn_bank | output | 2 | Dynamic bank index |
| mem_cs_n | output | 4 | Active-low select per static bank |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_addr | output | 25 | Byte address within the bank |
| mem_dout | output | 32 | Write data, on the low lanes for narrow banks |
| mem_din | input | 32 | Read data from memory |
| mem_wait | input | 1 | High stretches the current beat |

## Verification
The hardest case to reach from the ports is a wait that is high in the cycles of a beat where it must be ignored and then high or low in the last cycle, where it counts. The bench drives `mem_wait` from a counter of elapsed strobe cycles, holding it high for the first N cycles of an access. Combined with access counts of 0, 1 and 3, this places the high level in earlier cycles only, in the last cycle only, or in both. The resulting strobe length is then checked against the count predicted from R4 and R5. Byte and halfword placement is checked with a responder that returns each byte's own address as its data, so any lane swap or address slip shows up as a wrong byte value.

// File: rtl/stbank_pkg.sv
package stbank_pkg;

  localparam int WORD_W = 32;

  // width codes: anything else is a full-word bank
  localparam logic [1:0] BW8  = 2'd0;
  localparam logic [1:0] BW16 = 2'd1;

  // index of the final beat for a width code
  function automatic logic [1:0] last_beat(input logic [1:0] ws);
    case (ws)
      BW8:     return 2'd3;
      BW16:    return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  // byte increment of the external address between beats
  function automatic logic [2:0] beat_stride(input logic [1:0] ws);
    case (ws)
      BW8:     return 3'd1;
      BW16:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // word slot that a beat maps to; reversed for big-endian
  function automatic logic [1:0] word_slot(input logic [1:0] beat, input logic big);
    return big ? ~beat : beat;
  endfunction

  function automatic logic [WORD_W-1:0] lane_out(input logic [WORD_W-1:0] word,
                                                  input logic [1:0] beat,
                                                  input logic [1:0] ws,
                                                  input logic big);
    logic [1:0] s;
    s = word_slot(beat, big);
    case (ws)
      BW8:     return {24'd0, word[{s, 3'b000} +: 8]};
      BW16:    return {16'd0, word[{s[0], 4'b0000} +: 16]};
      default: return word;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] merge_in(input logic [WORD_W-1:0] cur,
                                                  input logic [WORD_W-1:0] din,
                                                  input logic [1:0] beat,
                                                  input logic [1:0] ws,
                                                  input logic big);
    logic [WORD_W-1:0] r;
    logic [1:0] s;
    r = cur;
    s = word_slot(beat, big);
    case (ws)
      BW8:     r[{s, 3'b000} +: 8] = din[7:0];
      BW16:    r[{s[0], 4'b0000} +: 16] = din[15:0];
      default: r = din;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/stbank_decode.sv
module stbank_decode #(
  parameter int ADDR_W   = 28,
  parameter int N_STATIC = 4,
  parameter int ACC_W    = 4,
  localparam int SB_W    = $clog2(N_STATIC),
  localparam int OFS_W   = ADDR_W - SB_W - 1
) (
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [2*N_STATIC-1:0]     cfg_width,
  input  logic [ACC_W*N_STATIC-1:0] cfg_acc,
  output logic                      is_dyn,
  output logic [SB_W-1:0]           bank,
  output logic [1:0]                ws,
  output logic [ACC_W-1:0]          acc,
  output logic [OFS_W-1:0]          base
);

  logic [1:0]       ws_arr  [N_STATIC];
  logic [ACC_W-1:0] acc_arr [N_STATIC];

  for (genvar b = 0; b < N_STATIC; b++) begin : g_bank
    assign ws_arr[b]  = cfg_width[2*b +: 2];
    assign acc_arr[b] = cfg_acc[ACC_W*b +: ACC_W];
  end

  logic unused_lsb;
  assign unused_lsb = ^req_addr[1:0];

  assign is_dyn = req_addr[ADDR_W-1];
  assign bank   = req_addr[ADDR_W-2 -: SB_W];
  assign ws     = ws_arr[bank];
  assign acc    = acc_arr[bank];
  assign base   = {req_addr[OFS_W-1:2], 2'b00};

endmodule

// File: rtl/stbank_seq.sv
module stbank_seq
  import stbank_pkg::*;
#(
  parameter int N_STATIC = 4,
  parameter int ACC_W    = 4,
  parameter int OFS_W    = 25,
  localparam int SB_W    = $clog2(N_STATIC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_we,
  input  logic [WORD_W-1:0]  req_wdata,
  input  logic               cfg_big,
  input  logic               is_dyn,
  input  logic [SB_W-1:0]    bank_in,
  input  logic [1:0]         ws_in,
  input  logic [ACC_W-1:0]   acc_in,
  input  logic [OFS_W-1:0]   base_in,
  output logic               resp_done,
  output logic [WORD_W-1:0]  resp_rdata,
  output logic               dyn_flag,
  output logic [SB_W-1:0]    dyn_bank,
  output logic [N_STATIC-1:0] mem_cs_n,
  output logic               mem_oe_n,
  output logic               mem_we_n,
  output logic [OFS_W-1:0]   mem_addr,
  output logic [WORD_W-1:0]  mem_dout,
  input  logic [WORD_W-1:0]  mem_din,
  input  logic               mem_wait
);

  logic              busy, we_q, big_q, done_q, dyn_q;
  logic [SB_W-1:0]   bank_q, dyn_bank_q;
  logic [OFS_W-1:0]  addr_q;
  logic [WORD_W-1:0] wdata_q, rdata_q;
  logic [1:0]        ws_q, beat_q;
  logic [ACC_W-1:0]  acc_q, cnt_q;

  // named internal events
  logic accept, last_cyc, beat_end, final_end;
  assign accept    = req_valid && !busy;
  assign last_cyc  = busy && (cnt_q == '0);
  assign beat_end  = last_cyc && !mem_wait;
  assign final_end = beat_end && (beat_q == last_beat(ws_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; we_q <= 1'b0; big_q <= 1'b0; done_q <= 1'b0; dyn_q <= 1'b0;
      bank_q <= '0; dyn_bank_q <= '0; addr_q <= '0; wdata_q <= '0; rdata_q <= '0;
      ws_q <= '0; beat_q <= '0; acc_q <= '0; cnt_q <= '0;
    end else begin
      done_q <= final_end;
      dyn_q  <= accept && is_dyn;
      if (accept && is_dyn) dyn_bank_q <= bank_in;
      if (accept && !is_dyn) begin
        busy    <= 1'b1;
        bank_q  <= bank_in;
        addr_q  <= base_in;
        we_q    <= req_we;
        wdata_q <= req_wdata;
        ws_q    <= ws_in;
        acc_q   <= acc_in;
        big_q   <= cfg_big;
        beat_q  <= '0;
        cnt_q   <= acc_in;
        rdata_q <= '0;
      end else if (busy) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end else if (beat_end) begin
          if (!we_q) rdata_q <= merge_in(rdata_q, mem_din, beat_q, ws_q, big_q);
          if (final_end) begin
            busy <= 1'b0;
          end else begin
            beat_q <= beat_q + 1'b1;
            addr_q <= addr_q + {{(OFS_W-3){1'b0}}, beat_stride(ws_q)};
            cnt_q  <= acc_q;
          end
        end
      end
    end
  end

  assign mem_cs_n   = busy ? ~(N_STATIC'(1) << bank_q) : '1;
  assign mem_oe_n   = !(busy && !we_q);
  assign mem_we_n   = !(busy && we_q);
  assign mem_addr   = addr_q;
  assign mem_dout   = (busy && we_q) ? lane_out(wdata_q, beat_q, ws_q, big_q) : '0;
  assign resp_done  = done_q;
  assign resp_rdata = rdata_q;
  assign dyn_flag   = dyn_q;
  assign dyn_bank   = dyn_bank_q;

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n)); // R6
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n)); // R6
  AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (last_cyc && mem_wait) |=> (busy && $stable(addr_q) && $stable(beat_q) && cnt_q == '0)); // R5
  AST_EARLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != '0) |=> (busy && $stable(beat_q) && $stable(mem_cs_n))); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |=> !resp_done); // R9
  AST_DYN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dyn_flag |-> (mem_cs_n == '1 && !resp_done)); // R2

endmodule

// File: rtl/stbank_ctrl.sv
module stbank_ctrl
  import stbank_pkg::*;
#(
  parameter int ADDR_W   = 28,
  parameter int N_STATIC = 4,
  parameter int ACC_W    = 4,
  localparam int SB_W    = $clog2(N_STATIC),
  localparam int OFS_W   = ADDR_W - SB_W - 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2*N_STATIC-1:0]     cfg_width,
  input  logic [ACC_W*N_STATIC-1:0] cfg_acc,
  input  logic                      cfg_big,
  input  logic                      req_valid,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic                      req_we,
  input  logic [WORD_W-1:0]         req_wdata,
  output logic                      resp_done,
  output logic [WORD_W-1:0]         resp_rdata,
  output logic                      dyn_flag,
  output logic [SB_W-1:0]           dyn_bank,
  output logic [N_STATIC-1:0]       mem_cs_n,
  output logic                      mem_oe_n,
  output logic                      mem_we_n,
  output logic [OFS_W-1:0]          mem_addr,
  output logic [WORD_W-1:0]         mem_dout,
  input  logic [WORD_W-1:0]         mem_din,
  input  logic                      mem_wait
);

  logic             dec_dyn;
  logic [SB_W-1:0]  dec_bank;
  logic [1:0]       dec_ws;
  logic [ACC_W-1:0] dec_acc;
  logic [OFS_W-1:0] dec_base;

  stbank_decode #(.ADDR_W(ADDR_W), .N_STATIC(N_STATIC), .ACC_W(ACC_W)) i_decode (
    .req_addr (req_addr),
    .cfg_width(cfg_width),
    .cfg_acc  (cfg_acc),
    .is_dyn   (dec_dyn),
    .bank     (dec_bank),
    .ws       (dec_ws),
    .acc      (dec_acc),
    .base     (dec_base)
  );

  stbank_seq #(.N_STATIC(N_STATIC), .ACC_W(ACC_W), .OFS_W(OFS_W)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_wdata (req_wdata),
    .cfg_big   (cfg_big),
    .is_dyn    (dec_dyn),
    .bank_in   (dec_bank),
    .ws_in     (dec_ws),
    .acc_in    (dec_acc),
    .base_in   (dec_base),
    .resp_done (resp_done),
    .resp_rdata(resp_rdata),
    .dyn_flag  (dyn_flag),
    .dyn_bank  (dyn_bank),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_addr  (mem_addr),
    .mem_dout  (mem_dout),
    .mem_din   (mem_din),
    .mem_wait  (mem_wait)
  );

endmodule

// File: tb/test_stbank_ctrl.sv
module test_stbank_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_width = '0;
  logic [15:0] cfg_acc = '0;
  logic        cfg_big = 1'b0;
  logic        req_valid = 1'b0;
  logic [27:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        resp_done, dyn_flag, mem_oe_n, mem_we_n;
  logic [31:0] resp_rdata, mem_dout, mem_din;
  logic [1:0]  dyn_bank;
  logic [3:0]  mem_cs_n;
  logic [24:0] mem_addr;
  logic        mem_wait = 1'b0;

  always #5 clk = ~clk;

  stbank_ctrl i_stbank_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_acc(cfg_acc), .cfg_big(cfg_big),
    .req_valid(req_valid), .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .resp_done(resp_done), .resp_rdata(resp_rdata), .dyn_flag(dyn_flag), .dyn_bank(dyn_bank),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .mem_din(mem_din), .mem_wait(mem_wait)
  );

  // memory model: every byte reads back the low 8 bits of its own address
  assign mem_din = {mem_addr[7:0] + 8'd3, mem_addr[7:0] + 8'd2, mem_addr[7:0] + 8'd1, mem_addr[7:0]};

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bus monitor and wait driver
  int          strobe_cnt, nbeats, seen, wait_n;
  logic [24:0] b_addr [4];
  logic [31:0] b_dout [4];
  logic [3:0]  b_cs   [4];
  logic        b_we   [4];
  logic        prev_act = 1'b0;
  logic [24:0] prev_addr = '0;

  always @(negedge clk) begin
    if (!mem_oe_n || !mem_we_n) begin
      strobe_cnt++;
      if ((!prev_act || mem_addr != prev_addr) && nbeats < 4) begin
        b_addr[nbeats] = mem_addr;
        b_dout[nbeats] = mem_dout;
        b_cs[nbeats]   = mem_cs_n;
        b_we[nbeats]   = !mem_we_n;
        nbeats++;
      end
      mem_wait = (seen < wait_n);
      seen++;
      prev_act  = 1'b1;
      prev_addr = mem_addr;
    end else begin
      mem_wait = 1'b0;
      prev_act = 1'b0;
    end
  end

  typedef struct packed {
    logic [27:0] addr;
    logic        we;
    logic [31:0] wdata;
    logic [1:0]  ws;
    logic [3:0]  acc;
    logic        big;
    logic [2:0]  waits;
    logic [2:0]  ext;
  } vec_t;

  // addr, we, wdata, width code, access count, big, wait cycles, expected stretch
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{28'h0000100, 1'b0, 32'h0,        2'd2, 4'd0,  1'b0, 3'd0, 3'd0},
    '{28'h2000040, 1'b0, 32'h0,        2'd1, 4'd1,  1'b0, 3'd0, 3'd0},
    '{28'h4000083, 1'b0, 32'h0,        2'd0, 4'd2,  1'b1, 3'd0, 3'd0},
    '{28'h6000010, 1'b1, 32'hA1B2C3D4, 2'd0, 4'd0,  1'b0, 3'd0, 3'd0},
    '{28'h6fffffc, 1'b1, 32'h12345678, 2'd1, 4'd1,  1'b1, 3'd0, 3'd0},
    '{28'h0000020, 1'b1, 32'hCAFEF00D, 2'd2, 4'd3,  1'b1, 3'd0, 3'd0},
    '{28'h2000300, 1'b0, 32'h0,        2'd1, 4'd0,  1'b1, 3'd3, 3'd3},
    '{28'h4000044, 1'b0, 32'h0,        2'd0, 4'd0,  1'b0, 3'd2, 3'd2},
    '{28'h0000408, 1'b1, 32'h0BADBEEF, 2'd0, 4'd0,  1'b1, 3'd1, 3'd1},
    '{28'h60000f0, 1'b0, 32'h0,        2'd2, 4'd15, 1'b0, 3'd0, 3'd0},
    '{28'h4000500, 1'b1, 32'h55AA00FF, 2'd3, 4'd1,  1'b0, 3'd0, 3'd0},
    '{28'h2000080, 1'b0, 32'h0,        2'd1, 4'd1,  1'b0, 3'd2, 3'd1}
  };

  task automatic run_vec(input vec_t v);
    int nb, bytes, lat, exp_cnt;
    logic [1:0]  bank;
    logic [24:0] base;
    logic [31:0] exp_word;
    bank  = v.addr[26:25];
    base  = {v.addr[24:2], 2'b00};
    nb    = (v.ws == 2'd0) ? 4 : (v.ws == 2'd1) ? 2 : 1;
    bytes = 4 / nb;
    @(negedge clk);
    for (int b = 0; b < 4; b++) begin
      cfg_width[2*b +: 2] = (b == int'(bank)) ? v.ws : ((v.ws == 2'd0) ? 2'd2 : 2'd0);
      cfg_acc[4*b +: 4]   = (b == int'(bank)) ? v.acc : ~v.acc;
    end
    cfg_big = v.big;
    strobe_cnt = 0; nbeats = 0; seen = 0; wait_n = int'(v.waits);
    req_valid = 1'b1; req_addr = v.addr; req_we = v.we; req_wdata = v.wdata;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) req_valid = 1'b0;
    end while (!resp_done && lat < 300);
    exp_cnt = nb * (int'(v.acc) + 1) + int'(v.ext);
    chk(strobe_cnt == exp_cnt, "R4/R5 strobe cycles", strobe_cnt, exp_cnt);
    chk(lat == exp_cnt + 1, "R9 completion cycle", lat, exp_cnt + 1);
    chk(nbeats == nb, "R3 beat count", nbeats, nb);
    chk(b_cs[0] == ~(4'b0001 << bank), "R1 bank select", {28'd0, b_cs[0]}, {28'd0, ~(4'b0001 << bank)});
    exp_word = '0;
    for (int k = 0; k < nb && k < nbeats; k++) begin
      logic [31:0] e;
      chk(b_addr[k] == 25'(int'(base) + k*bytes), "R3 beat address", {7'd0, b_addr[k]},
          32'(int'(base) + k*bytes));
      chk(b_we[k] == v.we, "R6 strobe kind", {31'd0, b_we[k]}, {31'd0, v.we});
      e = '0;
      for (int j = 0; j < bytes; j++) begin
        int idx, t;
        idx = ((v.big ? (nb - 1 - k) : k) * bytes) + j;
        t   = int'(base) + k*bytes + j;
        e[j*8 +: 8] = v.wdata[idx*8 +: 8];
        exp_word[idx*8 +: 8] = t[7:0];
      end
      if (v.we) chk(b_dout[k] == e, v.big ? "R8 write lanes" : "R7 write lanes", b_dout[k], e);
    end
    if (!v.we) chk(resp_rdata == exp_word, v.big ? "R8 read word" : "R7 read word", resp_rdata, exp_word);
  endtask

  logic finished = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (2) @(negedge clk);
    chk(mem_cs_n == 4'hF && mem_oe_n && mem_we_n, "R10 bus idle in reset",
        {26'd0, mem_cs_n, mem_oe_n, mem_we_n}, 32'h3F);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!resp_done && !dyn_flag && mem_cs_n == 4'hF, "R10 idle after reset",
        {29'd0, resp_done, dyn_flag, &mem_cs_n}, 32'h1);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R5: wait high only in non-final cycles of a beat has no effect
    run_vec('{28'h0000200, 1'b0, 32'h0, 2'd2, 4'd3, 1'b0, 3'd3, 3'd0});

    // R2: dynamic bank request
    @(negedge clk);
    strobe_cnt = 0; nbeats = 0; seen = 0; wait_n = 0;
    req_valid = 1'b1; req_addr = 28'hA000040; req_we = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(dyn_flag == 1'b1, "R2 dynamic flag", {31'd0, dyn_flag}, 32'd1);
    chk(dyn_bank == 2'd1, "R2 dynamic index", {30'd0, dyn_bank}, 32'd1);
    chk(mem_cs_n == 4'hF, "R2 no select", {28'd0, mem_cs_n}, 32'hF);
    @(negedge clk);
    chk(dyn_flag == 1'b0, "R2 flag single cycle", {31'd0, dyn_flag}, 32'd0);
    begin
      int hits;
      hits = 0;
      repeat (6) begin
        @(negedge clk);
        if (resp_done) hits++;
      end
      chk(hits == 0 && strobe_cnt == 0, "R2 no bus cycle, no completion", hits + strobe_cnt, 0);
    end

    // R11: request held during a running access is ignored
    @(negedge clk);
    cfg_width = 8'b10_10_10_00; cfg_acc = 16'h1111; cfg_big = 1'b0;
    strobe_cnt = 0; nbeats = 0; seen = 0; wait_n = 0;
    req_valid = 1'b1; req_addr = 28'h0000010; req_we = 1'b0;
    @(negedge clk);
    req_addr = 28'h4000020; req_we = 1'b1; req_wdata = 32'hFFFFFFFF;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    begin
      int n;
      n = 0;
      while (!resp_done && n < 100) begin
        @(negedge clk);
        n++;
      end
      chk(strobe_cnt == 8, "R11 only first access run", strobe_cnt, 8);
      chk(b_cs[0] == 4'hE && !b_we[0], "R11 first access bank", {28'd0, b_cs[0]}, 32'hE);
      repeat (6) @(negedge clk);
      chk(strobe_cnt == 8 && nbeats == 4, "R11 no second access", strobe_cnt, 8);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule